// File: doc/BRIEF.md
# Banked Filter Parameter Register File

This block stores several complete sets of filter coefficients, one set per video standard, and presents one of them to a filter datapath. Five banks exist. Bank 0 is for PAL B/G/H/I/D/K, bank 1 for PAL M, bank 2 for PAL N, bank 3 for NTSC and bank 4 for bypass. A host reaches the block over a plain synchronous bus with address, write data and write enable. Reads are combinational.

Address 0x00 holds a select byte with two bank pointers. Bits [2:0] point at the bank that host accesses use. Bits [6:4] point at the bank that drives the parameter outputs. Software can therefore load one standard's settings while a different standard stays live.

Every parameter write lands in a shadow copy. The working copies that feed the outputs take the shadow contents only on a one-cycle commit strobe, normally tied to vertical sync. The live bank pointer also moves only on that strobe, so the output set always switches as a whole.

Top module: `pbk_top`

## Requirements
- R1: After reset, every shadow and working register is 0, both pointers are 0, the select byte reads 0, `live_bank` is 0 and `param_out` is all zero.
- R2: A read of address 0x00 returns all 8 bits of the last byte written there.
- R3: A write to address 0x01..0x08, with the write pointer (select bits [2:0]) in 0..4, stores the data in shadow register (address−1) of that bank. A read of the same address returns the data from the next cycle on, before any commit.
- R4: `param_out` changes only in the cycle after `commit_stb` is high. Byte k of `param_out` (bits [8k+7:8k]) is working register k, which is address k+1. On the strobe edge, every bank's working copy takes its shadow copy.
- R5: A parameter write in the same cycle as `commit_stb` reaches the shadow copy. It is not committed by that strobe but by the next one.
- R6: A change to select bits [6:4] does not move `live_bank` or `param_out` until the next `commit_stb`. At that strobe the pointer takes the select byte value held before the strobe edge.
- R7: While the write pointer is 5..7, parameter writes are ignored and parameter reads return 0.
- R8: A live pointer of 5..7 selects bank 4, and `live_bank` then reads 4.
- R9: Banks are independent: a write to one bank leaves every other bank's shadow and working registers unchanged.
- R10: Writes to addresses 0x09..0x0F are ignored, and reads of those addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | 4 | Register address |
| host_wdata | input | 8 | Write data |
| host_we | input | 1 | Write enable |
| host_rdata | output | 8 | Read data for `host_addr` (combinational) |
| commit_stb | input | 1 | Commit strobe: shadow to working copy, latch live pointer |
| param_out | output | 64 | Working registers of the live bank, register 0 in the low byte |
| live_bank | output | 3 | Bank currently driving `param_out` |

## Verification
The bench drives a write in the same cycle as a strobe. A design that committed on the same edge would show the new byte one strobe early.

It rewrites the active field and then checks `live_bank` before the next strobe. A design that switched banks at once would change the outputs mid-field.

It sets the write pointer and the live pointer out of range. A design that aliased pointers 5..7 onto real banks would corrupt a bank or drive an undefined set.

It also writes past the last parameter address. A design with a loose address decode would wrap that write into register 0.

// File: rtl/pbk_pkg.sv
package pbk_pkg;
  localparam int PTR_W = 3;
  typedef logic [PTR_W-1:0] bank_ptr_t;

  // pointer names an existing bank
  function automatic logic ptr_ok(bank_ptr_t p, int nbanks);
    return int'(p) < nbanks;
  endfunction

  // out-of-range live pointers fall back to the last (bypass) bank
  function automatic bank_ptr_t ptr_live(bank_ptr_t p, int nbanks);
    return (int'(p) < nbanks) ? p : bank_ptr_t'(nbanks - 1);
  endfunction

  // address maps onto a parameter register (addresses 1..nregs)
  function automatic logic addr_is_param(int unsigned a, int nregs);
    return (a >= 1) && (a <= nregs);
  endfunction
endpackage

// File: rtl/pbk_select.sv
module pbk_select
  import pbk_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel_we,
  input  logic [DW-1:0] wdata,
  input  logic          commit,
  output logic [DW-1:0] sel_q,
  output bank_ptr_t     wr_ptr,
  output bank_ptr_t     act_ptr
);
  localparam int WR_LSB  = 0;
  localparam int ACT_LSB = 4;

  logic [DW-1:0] sel_r;
  bank_ptr_t     act_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_r <= '0;
    else if (sel_we) sel_r <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_r <= '0;
    else if (commit) act_r <= sel_r[ACT_LSB +: PTR_W];
  end

  assign sel_q   = sel_r;
  assign wr_ptr  = sel_r[WR_LSB +: PTR_W];
  assign act_ptr = act_r;

  // R6
  act_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> act_r == $past(sel_r[ACT_LSB +: PTR_W]));
  // R6
  act_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(act_r));
  // R2
  sel_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_we |=> sel_r == $past(wdata));
endmodule

// File: rtl/pbk_bank.sv
module pbk_bank #(
  parameter int NREG = 8,
  parameter int DW   = 8,
  parameter int IDXW = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [IDXW-1:0]          idx,
  input  logic [DW-1:0]            wdata,
  input  logic                     commit,
  output logic [NREG-1:0][DW-1:0]  shadow_v,
  output logic [NREG-1:0][DW-1:0]  work_v
);
  logic [NREG-1:0][DW-1:0] shadow_q;
  logic [NREG-1:0][DW-1:0] work_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shadow_q <= '0;
    else if (we) shadow_q[idx] <= wdata;
  end

  // commit copies the pre-edge shadow, so a same-cycle write waits a strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) work_q <= '0;
    else if (commit) work_q <= shadow_q;
  end

  assign shadow_v = shadow_q;
  assign work_v   = work_q;

  // R3
  shadow_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> shadow_q[$past(idx)] == $past(wdata));
  // R9
  shadow_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(shadow_q));
  // R5
  work_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> work_q == $past(shadow_q));
  // R4
  work_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(work_q));
endmodule

// File: rtl/pbk_top.sv
module pbk_top
  import pbk_pkg::*;
#(
  parameter int NBANK = 5,
  parameter int NREG  = 8,
  parameter int DW    = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [$clog2(NREG+1)-1:0]  host_addr,
  input  logic [DW-1:0]              host_wdata,
  input  logic                       host_we,
  output logic [DW-1:0]              host_rdata,
  input  logic                       commit_stb,
  output logic [NREG*DW-1:0]         param_out,
  output logic [PTR_W-1:0]           live_bank
);
  localparam int AW   = $clog2(NREG + 1);
  localparam int IDXW = $clog2(NREG);

  bank_ptr_t wr_ptr, act_ptr, live_ptr;
  logic [DW-1:0] sel_q;
  logic [AW-1:0] addr_m1;
  logic [IDXW-1:0] reg_idx;
  logic addr_param, sel_wr, par_wr, wr_ptr_ok;
  logic [NBANK-1:0] bank_we;
  logic [NREG-1:0][DW-1:0] shadow_all [NBANK];
  logic [NREG-1:0][DW-1:0] work_all   [NBANK];
  logic [NREG-1:0][DW-1:0] live_set;
  logic [NREG-1:0][DW-1:0] host_set;

  assign addr_m1    = host_addr - AW'(1);
  assign reg_idx    = addr_m1[IDXW-1:0];
  assign addr_param = addr_is_param(int'(host_addr), NREG);
  assign wr_ptr_ok  = ptr_ok(wr_ptr, NBANK);
  assign sel_wr     = host_we && (host_addr == '0);
  assign par_wr     = host_we && addr_param && wr_ptr_ok;
  assign live_ptr   = ptr_live(act_ptr, NBANK);

  pbk_select #(.DW(DW)) u_sel (
    .clk(clk), .rst_n(rst_n), .sel_we(sel_wr), .wdata(host_wdata),
    .commit(commit_stb), .sel_q(sel_q), .wr_ptr(wr_ptr), .act_ptr(act_ptr)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    assign bank_we[b] = par_wr && (int'(wr_ptr) == b);
    pbk_bank #(.NREG(NREG), .DW(DW), .IDXW(IDXW)) u_bank (
      .clk(clk), .rst_n(rst_n), .we(bank_we[b]), .idx(reg_idx),
      .wdata(host_wdata), .commit(commit_stb),
      .shadow_v(shadow_all[b]), .work_v(work_all[b])
    );
  end

  always_comb begin
    live_set = '0;
    host_set = '0;
    for (int b = 0; b < NBANK; b++) begin
      if (int'(live_ptr) == b) live_set = work_all[b];
      if (int'(wr_ptr) == b)   host_set = shadow_all[b];
    end
  end

  always_comb begin
    if (host_addr == '0)              host_rdata = sel_q;
    else if (addr_param && wr_ptr_ok) host_rdata = host_set[reg_idx];
    else                              host_rdata = '0;
  end

  assign param_out = live_set;
  assign live_bank = live_ptr;

  // R8
  live_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(live_bank) < NBANK);
  // R4
  param_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_stb |=> $stable(param_out));
  // R7
  bad_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ptr_ok |-> bank_we == '0);
  // R10
  bad_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_we && !addr_param) |-> $onehot0(bank_we) && bank_we == '0);
endmodule

// File: tb/sim_pbk_top.sv
module sim_pbk_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] host_addr = '0;
  logic [7:0] host_wdata = '0;
  logic host_we = 1'b0;
  logic commit_stb = 1'b0;
  logic [7:0] host_rdata;
  logic [63:0] param_out;
  logic [2:0] live_bank;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  pbk_top u0 (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_we(host_we), .host_rdata(host_rdata), .commit_stb(commit_stb),
    .param_out(param_out), .live_bank(live_bank)
  );

  localparam logic [3:0] OP_W = 4'd0, OP_WS = 4'd1, OP_S = 4'd2,
                         OP_RD = 4'd3, OP_PR = 4'd4, OP_LB = 4'd5;
  localparam int NV = 37;
  // {req, op, addr, data, expected}
  localparam logic [27:0] VEC [NV] = '{
    {4'd2,  OP_W,  4'h0, 8'h00, 8'h00},
    {4'd3,  OP_W,  4'h1, 8'h11, 8'h00},
    {4'd3,  OP_RD, 4'h1, 8'h00, 8'h11}, // R3 read before commit
    {4'd4,  OP_PR, 4'h1, 8'h00, 8'h00}, // R4 not yet live
    {4'd4,  OP_S,  4'h0, 8'h00, 8'h00},
    {4'd4,  OP_PR, 4'h1, 8'h00, 8'h11}, // R4 live after strobe
    {4'd2,  OP_W,  4'h0, 8'h01, 8'h00},
    {4'd2,  OP_RD, 4'h0, 8'h00, 8'h01}, // R2
    {4'd9,  OP_RD, 4'h1, 8'h00, 8'h00}, // R9 bank 1 untouched
    {4'd3,  OP_W,  4'h2, 8'h22, 8'h00},
    {4'd9,  OP_PR, 4'h2, 8'h00, 8'h00}, // R9 bank 0 live unaffected
    {4'd6,  OP_W,  4'h0, 8'h11, 8'h00},
    {4'd6,  OP_LB, 4'h0, 8'h00, 8'h00}, // R6 no early switch
    {4'd6,  OP_S,  4'h0, 8'h00, 8'h00},
    {4'd6,  OP_LB, 4'h0, 8'h00, 8'h01}, // R6 switched
    {4'd9,  OP_PR, 4'h2, 8'h00, 8'h22},
    {4'd9,  OP_PR, 4'h1, 8'h00, 8'h00}, // R9
    {4'd5,  OP_WS, 4'h3, 8'h33, 8'h00},
    {4'd5,  OP_PR, 4'h3, 8'h00, 8'h00}, // R5 not committed yet
    {4'd5,  OP_S,  4'h0, 8'h00, 8'h00},
    {4'd5,  OP_PR, 4'h3, 8'h00, 8'h33}, // R5
    {4'd7,  OP_W,  4'h0, 8'h16, 8'h00},
    {4'd7,  OP_W,  4'h1, 8'hAA, 8'h00},
    {4'd7,  OP_RD, 4'h1, 8'h00, 8'h00}, // R7 read returns 0
    {4'd7,  OP_W,  4'h0, 8'h11, 8'h00},
    {4'd7,  OP_RD, 4'h1, 8'h00, 8'h00}, // R7 write ignored
    {4'd10, OP_W,  4'h9, 8'h5A, 8'h00},
    {4'd10, OP_RD, 4'h9, 8'h00, 8'h00}, // R10
    {4'd10, OP_RD, 4'h1, 8'h00, 8'h00}, // R10 no wrap into reg 0
    {4'd8,  OP_W,  4'h0, 8'h04, 8'h00},
    {4'd8,  OP_W,  4'h4, 8'h44, 8'h00},
    {4'd8,  OP_W,  4'h0, 8'h74, 8'h00},
    {4'd8,  OP_S,  4'h0, 8'h00, 8'h00},
    {4'd8,  OP_LB, 4'h0, 8'h00, 8'h04}, // R8
    {4'd8,  OP_PR, 4'h4, 8'h00, 8'h44}, // R8
    {4'd2,  OP_RD, 4'h0, 8'h00, 8'h74}, // R2
    {4'd9,  OP_PR, 4'h1, 8'h00, 8'h00}  // R9 bank 4 reg 0 clean
  };

  task automatic chk(input int req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d: actual %02h expected %02h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pbyte(input logic [3:0] a);
    return param_out[(int'(a) - 1) * 8 +: 8];
  endfunction

  initial begin
    #(20 * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual hung expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    host_addr = 4'h0; #2;
    chk(1, host_rdata, 8'h00);
    chk(1, {5'd0, live_bank}, 8'h00);
    chk(1, param_out[7:0] | param_out[63:56], 8'h00);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [3:0] rq, op, ad;
      logic [7:0] dt, ex;
      {rq, op, ad, dt, ex} = VEC[i];
      @(negedge clk);
      host_we = 1'b0;
      commit_stb = 1'b0;
      host_addr = ad;
      host_wdata = dt;
      case (op)
        OP_W:  host_we = 1'b1;
        OP_WS: begin host_we = 1'b1; commit_stb = 1'b1; end
        OP_S:  commit_stb = 1'b1;
        OP_RD: begin #2; chk(int'(rq), host_rdata, ex); end
        OP_PR: begin #2; chk(int'(rq), pbyte(ad), ex); end
        default: begin #2; chk(int'(rq), {5'd0, live_bank}, ex); end
      endcase
    end

    // R1 reset mid-run clears everything
    @(negedge clk);
    host_we = 1'b0;
    commit_stb = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    host_addr = 4'h0; #2;
    chk(1, host_rdata, 8'h00);
    chk(1, {5'd0, live_bank}, 8'h00);
    chk(1, param_out[31:24], 8'h00);
    host_addr = 4'h1; #2;
    chk(1, host_rdata, 8'h00);
    @(negedge clk);
    commit_stb = 1'b1;
    @(negedge clk);
    commit_stb = 1'b0;
    #2;
    chk(1, param_out[7:0], 8'h00); // R1 shadow equals working after reset

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule